// File: doc/BRIEF.md
# Interleaved-Column ROM Read Bank

A synchronous read-only bank whose contents are fixed at elaboration time by a hexadecimal image parameter. The image is taken as one large number, first digit most significant, at four bits per digit. It is cut into rows of equal width. The row width is chosen so that the array stays close to square. Inside a row, the words are stored bit-interleaved: every physical column group holds the same bit position of all words in that row.

A read splits the address into two fields. The upper field drives a one-hot row decoder. The lower field drives a column select, and the column gather collects one bit from each per-bit column group to rebuild the word. A control stage turns chip select into an evaluate enable. While chip select is low, the active-low bitlines stay precharged and no wordline fires. On an evaluate cycle, a selected cell that stores a one discharges its bitline. An inverting output stage restores the true value and registers it on the clock edge.

Top module: `rom_interleaved_bank`

## Requirements
- R1: While `rst_n` is low at a rising edge, `dout` becomes zero on that edge and reads zero afterwards until a read loads it.
- R2: When `cs` is high at a rising edge and reset is inactive, the addressed word appears on `dout` right after that same edge (one register stage).
- R3: When `cs` is low at a rising edge, `dout` keeps its previous value, whatever `addr` does. All bitlines stay precharged and no wordline is active.
- R4: `addr[CB-1:0]` (CB = ceil(log2(words per row))) selects the word inside a row, and the remaining upper bits select the row. Word w of row r is the word at linear index r×WPR+w of the image. Its first image bit (the most significant side) lands on `dout[WB-1]`.
- R5: The words per row is the smallest k with (2×bytes per word×k)² ≥ total whole words. With the defaults (296-bit image, 2-byte words, 18 words) this gives 2 words per row, 32-bit rows, 10 rows and a 5-bit address.
- R6: If the image does not fill the last row, that row is padded with zeros on its most significant side. With the defaults, address 18 reads 0x0000 and address 19 reads 0x00 followed by the image's last byte.
- R7: An address whose row field is at or above the row count, or whose column field is at or above the words per row, reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select; high starts an evaluate on the edge |
| addr | input | AW | Read address, row field above column field |
| dout | output | WB | Registered read word |

## Verification
The assertions take as given that `cs` and `addr` are settled before each rising edge. They also assume that reset is applied for at least one edge before the first read, so that `dout` has a defined starting value. The bench changes inputs only on falling edges and holds reset for several cycles at the start. It checks the whole address space, including row codes beyond the populated rows. It also runs a stretch of random address changes with `cs` low, so that every checked edge sees stable, in-range control inputs.

// File: rtl/rom_bank_pkg.sv
// Package: elaboration-time helpers for the ROM bank geometry.
// Assumes positive arguments; all functions are used as constants only.
package rom_bank_pkg;

    // Smallest r with 2**r >= n (0 for n <= 1).
    function automatic int ceil_log2(input int n);
        int r;
        r = 0;
        while ((1 << r) < n) r++;
        return r;
    endfunction

    // Smallest k with (2*bytes*k)^2 >= words, keeps the array near square.
    function automatic int words_per_row(input int words, input int bytes);
        int k;
        k = 1;
        while ((2 * bytes * k) * (2 * bytes * k) < words) k++;
        return k;
    endfunction

    // Width of a field able to index n items, never below one bit.
    function automatic int field_w(input int n);
        return (ceil_log2(n) > 0) ? ceil_log2(n) : 1;
    endfunction

endpackage

// File: rtl/rom_row_decode.sv
// Row decoder: one-hot wordlines from the row field, fired only while
// the control stage enables evaluation. Row codes at or above ROWS
// select no wordline.
module rom_row_decode #(
    parameter int ROWS = 10,
    parameter int RWB  = 4
) (
    input  logic            en,
    input  logic [RWB-1:0]  row_addr,
    output logic [ROWS-1:0] wl
);
    for (genvar r = 0; r < ROWS; r++) begin : g_wl
        // Purpose: decode one wordline, gated by the evaluate enable.
        assign wl[r] = en && (row_addr == RWB'(r));
    end
endmodule

// File: rtl/rom_cell_array.sv
// Cell array: holds the image mapped into rows with bit-major column
// order and drives active-low bitlines. Assumes at most one wordline
// active; with none active every bitline stays precharged high.
module rom_cell_array #(
    parameter int                  IMG_BITS = 296,
    parameter logic [IMG_BITS-1:0] IMAGE    = '0,
    parameter int                  WB       = 16,
    parameter int                  WPR      = 2,
    parameter int                  ROWS     = 10,
    localparam int                 RB       = WB * WPR
) (
    input  logic            precharge,
    input  logic [ROWS-1:0] wl,
    output logic [RB-1:0]   bl_n
);
    localparam int PAD = ROWS * RB - IMG_BITS;

    // Stored value of physical column p in row r (bit-major interleave).
    function automatic logic cell_bit(input int r, input int p);
        int b, w, k, q, s;
        b = p / WPR;
        w = p % WPR;
        k = b + w * WB;
        q = r * RB + k;
        if (r == ROWS - 1) begin
            if (k < PAD) return 1'b0;
            s = q - PAD;
        end else begin
            s = q;
        end
        return IMAGE[IMG_BITS-1-s];
    endfunction

    for (genvar p = 0; p < RB; p++) begin : g_col
        logic [ROWS-1:0] cells;
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            assign cells[r] = cell_bit(r, p);
        end
        // Purpose: a selected cell storing one discharges the bitline.
        assign bl_n[p] = precharge ? 1'b1 : ~|(wl & cells);
    end

    // Purpose: guard the single-row assumption of the wired bitlines.
    always_comb begin
        a_r4_single_row: assert ($onehot0(wl));
    end
endmodule

// File: rtl/rom_col_gather.sv
// Column gather: rebuilds one word by taking bit b of word w from
// physical column b*WPR+w. With no select active the output stays at
// the precharged (all ones, active-low) level.
module rom_col_gather #(
    parameter int WB  = 16,
    parameter int WPR = 2
) (
    input  logic [WB*WPR-1:0] bl_n,
    input  logic [WPR-1:0]    sel,
    output logic [WB-1:0]     word_n
);
    // Purpose: pick the selected word's columns out of each bit group.
    always_comb begin
        word_n = '1;
        for (int w = 0; w < WPR; w++) begin
            if (sel[w]) begin
                for (int b = 0; b < WB; b++) begin
                    word_n[WB-1-b] = bl_n[b*WPR + w];
                end
            end
        end
    end

    // Purpose: the column decoder must never open two words at once.
    always_comb begin
        a_r4_single_col: assert ($onehot0(sel));
    end
endmodule

// File: rtl/rom_interleaved_bank.sv
// Top: ROM read bank. Splits the address, generates the precharge and
// evaluate controls from chip select, decodes column selects, and
// registers the inverted gathered word. Assumes cs/addr settle before
// the rising edge; reset is synchronous and active low.
module rom_interleaved_bank
    import rom_bank_pkg::*;
#(
    parameter int                  WORD_BYTES = 2,
    parameter int                  IMG_BITS   = 296,
    parameter logic [IMG_BITS-1:0] IMAGE      =
        296'h1F2E3D4C5B6A79880F1E2D3C4B5A69788796A5B4C3D2E1F0F0E1D2C3B4A5968778695A4BC7,
    localparam int WB   = WORD_BYTES * 8,
    localparam int WPR  = words_per_row(IMG_BITS / WB, WORD_BYTES),
    localparam int RB   = WB * WPR,
    localparam int ROWS = (IMG_BITS + RB - 1) / RB,
    localparam int CB   = ceil_log2(WPR),
    localparam int CBW  = field_w(WPR),
    localparam int RWB  = field_w(ROWS),
    localparam int AW   = RWB + CB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic [AW-1:0] addr,
    output logic [WB-1:0] dout
);
    logic            precharge;
    logic            eval_en;
    logic [RWB-1:0]  row_addr;
    logic [CBW-1:0]  col_addr;
    logic [ROWS-1:0] wl;
    logic [WPR-1:0]  sel;
    logic [RB-1:0]   bl_n;
    logic [WB-1:0]   word_n;

    // Purpose: control stage, precharge when idle, evaluate when selected.
    assign precharge = ~cs;
    assign eval_en   = cs;

    assign row_addr = addr[AW-1 -: RWB];
    if (CB > 0) begin : g_col_field
        assign col_addr = addr[CBW-1:0];
    end else begin : g_no_col_field
        assign col_addr = '0;
    end

    for (genvar w = 0; w < WPR; w++) begin : g_sel
        // Purpose: column decode of one word select line.
        assign sel[w] = (col_addr == CBW'(w));
    end

    rom_row_decode #(.ROWS(ROWS), .RWB(RWB)) u_rowdec (
        .en       (eval_en),
        .row_addr (row_addr),
        .wl       (wl)
    );

    rom_cell_array #(
        .IMG_BITS (IMG_BITS),
        .IMAGE    (IMAGE),
        .WB       (WB),
        .WPR      (WPR),
        .ROWS     (ROWS)
    ) u_array (
        .precharge (precharge),
        .wl        (wl),
        .bl_n      (bl_n)
    );

    rom_col_gather #(.WB(WB), .WPR(WPR)) u_gather (
        .bl_n   (bl_n),
        .sel    (sel),
        .word_n (word_n)
    );

    // Purpose: inverting output stage, loaded on evaluate cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n)  dout <= '0;
        else if (cs) dout <= ~word_n;
    end

    // Purpose: reset clears the output register.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> dout == '0);

    // Purpose: an idle cycle leaves the output untouched.
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> $stable(dout));

    // Purpose: while idle every bitline rests at the precharged level.
    always_comb begin
        a_r3_precharged: assert (cs || &bl_n);
    end

    // Purpose: rows beyond the populated array read as zero.
    a_r7_row_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && (int'(row_addr) >= ROWS)) |=> dout == '0);
endmodule

// File: tb/sim_rom_interleaved_bank.sv
module sim_rom_interleaved_bank;
    localparam int TOTAL = 296;
    localparam logic [TOTAL-1:0] IMG =
        296'h1F2E3D4C5B6A79880F1E2D3C4B5A69788796A5B4C3D2E1F0F0E1D2C3B4A5968778695A4BC7;
    // Geometry from R5: 18 words -> 2 per row, 32-bit rows, 10 rows.
    localparam int WBT = 16, WPRT = 2, RBT = 32, ROWST = 10, AWT = 5;
    localparam int PADT = ROWST * RBT - TOTAL;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cs = 1'b0;
    logic [AWT-1:0] addr = '0;
    logic [WBT-1:0] dout;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    checking = 1'b0;
    bit    done = 1'b0;
    logic [WBT-1:0] exp_q = '0;
    string tag_q = "R1";
    string phase = "R1";

    always #2 clk = ~clk;

    rom_interleaved_bank u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (cs),
        .addr  (addr),
        .dout  (dout)
    );

    // Reference word from the linear word index (R4, R6, R7).
    function automatic logic [WBT-1:0] ref_word(input int a);
        logic [WBT-1:0] v;
        int row, col, q, k;
        v = '0;
        row = a / WPRT;
        col = a % WPRT;
        if (row >= ROWST) return '0;
        for (int b = 0; b < WBT; b++) begin
            q = a * WBT + b;
            if (row == ROWST - 1) begin
                k = q - row * RBT;
                v[WBT-1-b] = (k < PADT) ? 1'b0 : IMG[TOTAL-1-(q-PADT)];
            end else begin
                v[WBT-1-b] = IMG[TOTAL-1-q];
            end
        end
        return v;
    endfunction

    function automatic string addr_tag(input int a);
        if (a / WPRT >= ROWST) return "R7";
        if (a / WPRT == ROWST - 1) return "R6";
        return "R4";
    endfunction

    // Reference model step on every rising edge.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            exp_q <= '0;
            tag_q <= "R1";
        end else if (cs) begin
            exp_q <= ref_word(int'(addr));
            tag_q <= (phase == "R4") ? addr_tag(int'(addr)) : phase;
        end else begin
            tag_q <= "R3";
        end
    end

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (checking) begin
            n_vec++;
            if (dout !== exp_q) begin
                n_bad++;
                $display("FAIL %s addr-cycle %0d: dout=%h expected=%h",
                         tag_q, cycles, dout, exp_q);
            end
        end
    end

    task automatic step(input bit c, input int a);
        @(negedge clk);
        cs   = c;
        addr = AWT'(a);
    endtask

    // Explicit check on the current output against a fixed value.
    task automatic expect_now(input string tag, input logic [WBT-1:0] e);
        @(negedge clk);
        n_vec++;
        if (dout !== e) begin
            n_bad++;
            $display("FAIL %s: dout=%h expected=%h", tag, dout, e);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        checking = 1'b1;
        rst_n = 1'b1;
        // R1: output is zero out of reset.
        expect_now("R1", 16'h0000);
        // R4 R6 R7: sweep the whole address space with cs high.
        phase = "R4";
        for (int a = 0; a < (1 << AWT); a++) step(1'b1, a);
        // R5: geometry, address 2 is row 1 word 0.
        phase = "R5";
        step(1'b1, 2);
        expect_now("R5", 16'h5B6A);
        // R6: padded last row.
        phase = "R6";
        step(1'b1, 18);
        expect_now("R6", 16'h0000);
        step(1'b1, 19);
        expect_now("R6", 16'h00C7);
        // R3: address churn with cs low keeps the last word.
        for (int i = 0; i < 40; i++) step(1'b0, int'($urandom_range(0, 31)));
        expect_now("R3", 16'h00C7);
        // R2: mixed traffic, one-cycle latency.
        phase = "R2";
        for (int i = 0; i < 300; i++)
            step(1'($urandom_range(0, 1)), int'($urandom_range(0, 31)));
        // R1: reset in the middle of a run.
        step(1'b1, 1);
        @(negedge clk);
        rst_n = 1'b0;
        cs = 1'b1;
        expect_now("R1", 16'h0000);
        rst_n = 1'b1;
        cs = 1'b0;
        expect_now("R1", 16'h0000);
        step(1'b0, 0);
        checking = 1'b0;
        done = 1'b1;
    end

    initial begin
        wait (done || cycles > 20000);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: cycles=%0d expected=completion", cycles);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule